// File: doc/BRIEF.md
# Serial Register Access Slave with Status Byte

This block is a serial slave that lets an external controller read and write a small bank of 8-bit registers over a four-wire serial link. The link has an active-low select, a serial clock, a data input and a data output. Each frame begins with a command byte that carries a register address and a direction flag. One, two or three data bytes follow it. While the command byte arrives, the slave returns a global status byte that it takes from its `statusIn` port at the start of the frame. During each data byte it returns the contents of the addressed register.

A write frame returns the old value of each register and then stores the new byte. A read frame returns the current values and changes nothing. Later data bytes in a frame go to consecutive addresses. The bank holds a general-purpose scratch register at address 0Fh and a mode register at address 10h. The mode register drives the `modeOut` port.

The serial inputs are oversampled by the system clock `clk` through two-stage synchronisers. The serial clock must stay high and stay low for at least four `clk` periods per phase. It idles low, so the rising edge samples and the falling edge launches.

Top module: `spi_regslave`

## Requirements
- R1: After reset the scratch register (address 0Fh) holds 00h, the mode register (address 10h) holds 04h, `modeOut` is 04h and `sdoEn` is low.
- R2: `sdoEn` is high exactly while `csN` is low, lagging `csN` by two `clk` cycles of synchroniser delay.
- R3: The first 8 bits shifted out in every frame are the `statusIn` value captured when the select falling edge is detected. They are sent MSB first, whatever the command is.
- R4: The command byte is received MSB first. Bits 7:1 are the 7-bit register address, and bit 0 selects the direction (1 = write, 0 = read). All data bytes travel MSB first in both directions.
- R5: On a write, each data byte shifted out is the addressed register's value before the frame changed it. The register takes the received byte once all 8 of its bits are in.
- R6: On a read, each data byte shifted out is the register's current value, and no register changes.
- R7: A frame of 16, 24 or 32 clocks carries one, two or three data bytes. The second and third data bytes address the register one and two above the command address.
- R8: If the select rises during the command byte or during a data byte, no write happens for that partial byte. Bits after the 32nd cause no write.
- R9: Addresses other than 0Fh and 10h read as 00h, and writes to them have no effect.
- R10: The data input is sampled on the rising serial clock edge. The data output changes only after a falling serial clock edge or at frame start, never after a rising edge.
- R11: `modeOut` always shows the mode register's current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial link |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from controller |
| statusIn | input | 8 | Global status bits, captured at frame start |
| sdo | output | 1 | Serial data to controller |
| sdoEn | output | 1 | Drive enable for `sdo`; low means high impedance |
| modeOut | output | 8 | Current mode register contents |

## Verification
The assertions assume that the serial clock idles low and changes only while the select is low. They also assume that each serial clock phase lasts several system clocks, so that every edge is seen as exactly one strobe. The stimulus keeps to this: the bench drives every phase for six system clocks, moves the data input only while the serial clock is low, and holds `statusIn` steady from before the select falls until the frame ends. Random frames draw addresses near and across the two mapped registers, along with random addresses, directions and lengths, including truncated frames. Directed frames cover the reset values, the wrap from scratch into mode during auto-increment, and the unmapped addresses.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

  typedef struct packed {
    logic loadStatus;  // frame start: put status byte into transmit shifter
    logic shiftIn;     // rising serial clock: take one input bit
    logic cmdDone;     // eighth rising edge: command byte complete
    logic dataDone;    // a data byte inside the 32-bit window complete
    logic shiftOut;    // falling edge inside a byte: advance output
    logic loadNext;    // falling edge after a byte boundary: present next byte
  } strobe_t;

  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int REG_COUNT = 2;

  // Entry 0 is the scratch register, entry 1 the mode register.
  localparam logic [REG_COUNT-1:0][ADDR_W-1:0] REG_ADDR = {7'h10, 7'h0F};
  localparam logic [REG_COUNT-1:0][DATA_W-1:0] REG_RST  = {8'h04, 8'h00};
  localparam int MODE_IDX = 1;

endpackage

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_regslave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BITS    = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output strobe_t st,
  output logic    sdiBit,
  output logic    active
);

  localparam int CNT_W = $clog2(MAX_BITS) + 1;
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(7);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(15);
  localparam logic [CNT_W-1:0] BIT_LIMIT  = CNT_W'(MAX_BITS);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic csPrev, sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic csNow, sclkNow, csFall, sclkRise, sclkFall, atBoundary;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      csPrev   <= csPipe[SYNC_STAGES-1];
      sclkPrev <= sclkPipe[SYNC_STAGES-1];
    end
  end

  assign csNow    = csPipe[SYNC_STAGES-1];
  assign sclkNow  = sclkPipe[SYNC_STAGES-1];
  assign active   = ~csNow;
  assign csFall   = ~csNow & csPrev;
  assign sclkRise = active & sclkNow & ~sclkPrev;
  assign sclkFall = active & ~sclkNow & sclkPrev;
  assign sdiBit   = sdiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != '1) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign atBoundary = (bitCnt[2:0] == 3'd0) && (bitCnt != '0);

  always_comb begin
    st            = '0;
    st.loadStatus = csFall;
    st.shiftIn    = sclkRise && !csFall;
    st.cmdDone    = st.shiftIn && (bitCnt == CMD_LAST);
    st.dataDone   = st.shiftIn && (bitCnt[2:0] == 3'd7) &&
                    (bitCnt >= DATA_FIRST) && (bitCnt < BIT_LIMIT);
    st.shiftOut   = sclkFall && !csFall && !atBoundary;
    st.loadNext   = sclkFall && !csFall && atBoundary;
  end

endmodule

// File: rtl/spi_dpath.sv
module spi_dpath
  import spi_regslave_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              sdiBit,
  input  logic [DATA_W-1:0] statusIn,
  output logic              sdo,
  output logic [DATA_W-1:0] modeOut,
  output logic              isWrite
);

  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] fullByte, txShift, txNext, rdCmd, rdNext;
  logic [ADDR_W-1:0] curAddr, nextAddr;
  logic [DATA_W-1:0] bank [REG_COUNT];

  function automatic logic [DATA_W-1:0] lookup(input logic [ADDR_W-1:0] a,
                                               input logic [DATA_W-1:0] b [REG_COUNT]);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (a == REG_ADDR[i]) v = b[i];
    end
    return v;
  endfunction

  assign fullByte = {rxShift, sdiBit};
  assign nextAddr = curAddr + 1'b1;

  always_comb begin
    rdCmd  = lookup(fullByte[DATA_W-1:1], bank);
    rdNext = lookup(nextAddr, bank);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      txNext  <= '0;
      curAddr <= '0;
      isWrite <= 1'b0;
    end else if (st.loadStatus) begin
      txShift <= statusIn;
      rxShift <= '0;
      isWrite <= 1'b0;
    end else begin
      if (st.shiftIn) rxShift <= fullByte[DATA_W-2:0];
      if (st.cmdDone) begin
        curAddr <= fullByte[DATA_W-1:1];
        isWrite <= fullByte[0];
        txNext  <= rdCmd;
      end
      if (st.dataDone) begin
        curAddr <= nextAddr;
        txNext  <= rdNext;
      end
      if (st.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (st.loadNext) txShift <= txNext;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[g] <= REG_RST[g];
      end else if (st.dataDone && isWrite && curAddr == REG_ADDR[g]) begin
        bank[g] <= fullByte;
      end
    end
  end

  assign sdo     = txShift[DATA_W-1];
  assign modeOut = bank[MODE_IDX];

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_BITS    = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic [7:0] statusIn,
  output logic       sdo,
  output logic       sdoEn,
  output logic [7:0] modeOut
);

  strobe_t st;
  logic    sdiBit;
  logic    dpIsWrite;

  spi_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MAX_BITS(MAX_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .st(st), .sdiBit(sdiBit), .active(sdoEn)
  );

  spi_dpath u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .sdiBit(sdiBit), .statusIn(statusIn),
    .sdo(sdo), .modeOut(modeOut), .isWrite(dpIsWrite)
  );

endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
  import spi_regslave_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [7:0] statusIn,
  input logic       sdo,
  input logic       sdoEn,
  input logic [7:0] modeOut,
  input strobe_t    st,
  input logic       isWrite
);

  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 1'b1;
  end

  AST_OE_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (sdoEn == !$past(csN, 2)));  // R2

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    st.loadStatus |=> (sdo == $past(statusIn[7])));  // R3

  AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!st.shiftOut && !st.loadNext && !st.loadStatus) |=> $stable(sdo));  // R10

  AST_MODE_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !(st.dataDone && isWrite) |=> $stable(modeOut));  // R8

  AST_READ_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (st.dataDone && !isWrite) |=> $stable(modeOut));  // R6

endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .statusIn(statusIn), .sdo(sdo),
  .sdoEn(sdoEn), .modeOut(modeOut), .st(st), .isWrite(dpIsWrite)
);

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] statusIn = '0;
  logic       sdo, sdoEn;
  logic [7:0] modeOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] mScratch = 8'h00;
  logic [7:0] mMode = 8'h04;

  always #5 clk = ~clk;

  spi_regslave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .statusIn(statusIn), .sdo(sdo), .sdoEn(sdoEn), .modeOut(modeOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mdlRead(input logic [6:0] a);
    if (a == 7'h0F) return mScratch;
    if (a == 7'h10) return mMode;
    return 8'h00;
  endfunction

  task automatic runFrame(input logic [31:0] mosi, input int nBits,
                          output logic [31:0] miso);
    int holdBad;
    holdBad = 0;
    miso = '0;
    @(negedge clk);
    csN = 1'b0;
    sdi = mosi[31];
    repeat (HALF) @(negedge clk);
    check(sdoEn === 1'b1, "R2", 32'(sdoEn), 1);
    for (int i = 0; i < nBits; i++) begin
      sdi = mosi[31-i];
      repeat (HALF) @(negedge clk);
      miso[31-i] = sdo;
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      if (sdo !== miso[31-i]) holdBad++;
      repeat (HALF - 3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    check(holdBad == 0, "R10", 32'(holdBad), 0);
    check(sdoEn === 1'b0, "R2", 32'(sdoEn), 0);
  endtask

  task automatic doFrame(input logic [6:0] addr, input bit wr, input int nBits,
                         input logic [23:0] data, input string tag);
    logic [31:0] miso;
    logic [7:0]  stat, exp, got;
    logic [6:0]  a;
    int          nFull;
    string       req;
    stat = 8'($urandom);
    statusIn = stat;
    runFrame({addr, wr, data}, nBits, miso);
    if (nBits >= 8) check(miso[31:24] == stat, "R3", 32'(miso[31:24]), 32'(stat));
    nFull = nBits / 8 - 1;
    if (nFull > 3) nFull = 3;
    for (int k = 0; k < nFull; k++) begin
      a   = addr + 7'(k);
      exp = mdlRead(a);
      got = miso[23 - 8*k -: 8];
      req = (tag != "") ? tag : (k > 0 ? "R7" : (wr ? "R5" : "R6"));
      check(got == exp, req, 32'(got), 32'(exp));
      if (wr) begin
        if (a == 7'h0F) mScratch = data[23 - 8*k -: 8];
        if (a == 7'h10) mMode    = data[23 - 8*k -: 8];
      end
    end
    check(modeOut == mMode, "R11", 32'(modeOut), 32'(mMode));
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7321);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports and through a read
    check(sdoEn === 1'b0, "R1", 32'(sdoEn), 0);
    check(modeOut == 8'h04, "R1", 32'(modeOut), 32'h04);
    doFrame(7'h0F, 1'b0, 24, 24'h0, "R1");

    // R5: write returns old mode value
    doFrame(7'h10, 1'b1, 16, 24'hA5_0000, "R5");
    // R4: address/direction decode, read back
    doFrame(7'h10, 1'b0, 16, 24'h0, "R4");
    // R7: 32-bit write across unmapped, scratch, mode
    doFrame(7'h0E, 1'b1, 32, 24'h11_22_33, "R7");
    doFrame(7'h0E, 1'b0, 32, 24'h0, "R7");
    // R8: partial second data byte, then partial command
    doFrame(7'h0F, 1'b1, 20, 24'h5A_C3_00, "");
    check(modeOut == 8'h33, "R8", 32'(modeOut), 32'h33);
    doFrame(7'h10, 1'b1, 6, 24'hFF_FF_FF, "");
    check(modeOut == 8'h33, "R8", 32'(modeOut), 32'h33);
    doFrame(7'h0F, 1'b0, 24, 24'h0, "R8");
    // R9: unmapped address write then read
    doFrame(7'h20, 1'b1, 16, 24'hFF_0000, "R9");
    doFrame(7'h20, 1'b0, 16, 24'h0, "R9");

    // Random frames
    for (int n = 0; n < 60; n++) begin
      logic [6:0] ra;
      int         len;
      case ($urandom % 5)
        0: ra = 7'h0E;
        1: ra = 7'h0F;
        2: ra = 7'h10;
        3: ra = 7'h11;
        default: ra = 7'($urandom);
      endcase
      len = ($urandom % 6 == 0) ? int'($urandom % 31) + 1 : 8 * (int'($urandom % 3) + 2);
      doFrame(ra, 1'($urandom), len, 24'($urandom), "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule